// File: doc/BRIEF.md
# Shared-Pin GPIO Port with Bus Strobe Ownership

This block is a five-pin general-purpose I/O port whose pins double as the control strobes of an external memory bus. These strobes are address latch enable, output enable, write strobe high, write strobe low and byte address bit zero. A processor writes and reads three registers through a small register interface: an output data latch, a direction register, and a pin-level read path. Each pad is fed either by the port logic or by the bus controller's strobe. An ownership state machine picks the source from three inputs: a bus-disable control bit, an indication that code runs from internal program memory, and a flag for the 8-bit external bus mode.

The ownership state machine has three states. `OWN_BUS` is the reset state, in which all pins carry strobes. In `OWN_NARROW`, only the write-high pin (bit 3) belongs to the port. In `OWN_PORT`, all pins are general I/O. Every clock the machine evaluates its inputs. The transition T_RELEASE enters `OWN_PORT` when the bus is disabled and execution is internal. The transition T_NARROW enters `OWN_NARROW` when execution is external on the 8-bit bus. The transition T_RECLAIM returns to `OWN_BUS` in every other case. Pad drive is modelled as separate output, output-enable and input vectors, so the tristate pad stays outside the block.

Top module: `busmux_gpio_port`

## Requirements
- R1: After reset the direction register reads 5'h1F (all inputs) and the data latch reads 5'h00. All five pads are driven (pad_oe = 5'h1F) with pad_out equal to bus_strobe.
- R2: A write to register address 2'd1 (latch) stores reg_wdata in the data latch. Reading address 2'd1 returns the stored value.
- R3: A write to register address 2'd0 (port) also stores reg_wdata in the same data latch.
- R4: In port ownership, each pin whose direction bit is 0 drives its data latch bit on pad_out with pad_oe high. Writing 5'h04 to the direction register gives pad_oe = 5'b11011.
- R5: In port ownership, a direction bit of 1 holds that pin's pad_oe low. A read of address 2'd2 returns the direction register.
- R6: A read of address 2'd0 returns pad_in through a two-flop synchronizer. The value read lags the pins by two clocks.
- R7: Port ownership (`OWN_PORT`) requires bus_disable = 1 and exec_internal = 1. The pads follow the new owner one clock after the inputs change.
- R8: With exec_internal = 0 and narrow_bus = 1, only pin 3 follows the port registers. The other pins drive bus_strobe, whatever the value of bus_disable.
- R9: In every other combination of the mode inputs, all pins drive bus_strobe with pad_oe = 5'h1F.
- R10: A read of address 2'd1 returns the latch contents, not the pad level, even when the pins differ.
- R11: Address 2'd3 is reserved. It reads 5'h00, and writes to it change neither the latch nor the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_disable | input | 1 | External bus disable control bit |
| exec_internal | input | 1 | 1 while code executes from internal program memory |
| narrow_bus | input | 1 | 1 when the external bus runs in 8-bit mode |
| bus_strobe | input | 5 | Strobe values from the bus controller, one per pin |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address: 0 port, 1 latch, 2 direction, 3 reserved |
| reg_wdata | input | 5 | Register write data |
| reg_rdata | output | 5 | Register read data (combinational from reg_addr) |
| pad_in | input | 5 | Pin levels from the pads |
| pad_out | output | 5 | Value presented to each pad driver |
| pad_oe | output | 5 | Pad driver enable, 1 = driving |

## Verification
The ownership logic is driven through all mode combinations that matter. These are port mode, internal execution with the bus enabled, external execution on the 8-bit bus with the disable bit both set and clear, and external execution on the 16-bit bus. Distinct strobe and latch patterns are applied in each combination, so the bench can tell which source reaches every pin. The direction pattern 5'h04 separates driven pins from input pins. A pin pattern that differs from the latch separates the latch read path from the port read path. Sampling one and two clocks after a pin change tells the synchronizer lag apart from a direct path.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

    localparam int REG_AW = 2;

    localparam logic [REG_AW-1:0] ADDR_PORT = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_LAT  = 2'd1;
    localparam logic [REG_AW-1:0] ADDR_DIR  = 2'd2;
    localparam logic [REG_AW-1:0] ADDR_RSVD = 2'd3;

    localparam int SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        OWN_BUS    = 2'd0,
        OWN_NARROW = 2'd1,
        OWN_PORT   = 2'd2
    } own_e;

endpackage

// File: rtl/gpio_mux_sync.sv
module gpio_mux_sync #(
    parameter int W     = 5,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);

    logic [W-1:0] stage_q [DEPTH];

    genvar s;
    generate
        for (s = 0; s < DEPTH; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_out = stage_q[DEPTH-1];

endmodule

// File: rtl/gpio_mux_regs.sv
module gpio_mux_regs
    import gpio_mux_pkg::*;
#(
    parameter int W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [W-1:0]      reg_wdata,
    input  logic [W-1:0]      pin_sync,
    output logic [W-1:0]      reg_rdata,
    output logic [W-1:0]      lat_q,
    output logic [W-1:0]      dir_q
);

    logic hit_lat;
    logic hit_dir;

    assign hit_lat = reg_we && (reg_addr == ADDR_LAT || reg_addr == ADDR_PORT);
    assign hit_dir = reg_we && (reg_addr == ADDR_DIR);

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '0;
            dir_q <= '1;
        end else begin
            if (hit_lat) lat_q <= reg_wdata;
            if (hit_dir) dir_q <= reg_wdata;
        end
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_PORT: reg_rdata = pin_sync;
            ADDR_LAT:  reg_rdata = lat_q;
            ADDR_DIR:  reg_rdata = dir_q;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_mux_owner.sv
module gpio_mux_owner
    import gpio_mux_pkg::*;
#(
    parameter int W          = 5,
    parameter int NARROW_PIN = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bus_disable,
    input  logic         exec_internal,
    input  logic         narrow_bus,
    output own_e         own_state,
    output logic [W-1:0] port_mask
);

    own_e state_q;
    own_e state_d;
    logic go_port;
    logic go_narrow;

    assign go_port   = bus_disable && exec_internal;
    assign go_narrow = !exec_internal && narrow_bus;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OWN_BUS: begin
                if (go_port)        state_d = OWN_PORT;    // T_RELEASE
                else if (go_narrow) state_d = OWN_NARROW;  // T_NARROW
            end
            OWN_NARROW: begin
                if (go_port)         state_d = OWN_PORT;   // T_RELEASE
                else if (!go_narrow) state_d = OWN_BUS;    // T_RECLAIM
            end
            OWN_PORT: begin
                if (go_narrow)     state_d = OWN_NARROW;   // T_NARROW
                else if (!go_port) state_d = OWN_BUS;      // T_RECLAIM
            end
            default: state_d = OWN_BUS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= OWN_BUS;
        else     state_q <= state_d;
    end

    always_comb begin
        port_mask = '0;
        unique case (state_q)
            OWN_BUS:    port_mask = '0;
            OWN_NARROW: port_mask[NARROW_PIN] = 1'b1;
            OWN_PORT:   port_mask = '1;
            default:    port_mask = '0;
        endcase
    end

    assign own_state = state_q;

endmodule

// File: rtl/busmux_gpio_port.sv
module busmux_gpio_port
    import gpio_mux_pkg::*;
#(
    parameter int W          = 5,
    parameter int NARROW_PIN = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_disable,
    input  logic              exec_internal,
    input  logic              narrow_bus,
    input  logic [W-1:0]      bus_strobe,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      reg_rdata,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_oe
);

    logic [W-1:0] pin_sync;
    logic [W-1:0] lat_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] port_mask;
    own_e         own_state;

    gpio_mux_sync #(.W(W), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (pad_in),
        .q_out (pin_sync)
    );

    gpio_mux_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .pin_sync  (pin_sync),
        .reg_rdata (reg_rdata),
        .lat_q     (lat_q),
        .dir_q     (dir_q)
    );

    gpio_mux_owner #(.W(W), .NARROW_PIN(NARROW_PIN)) u_owner (
        .clk           (clk),
        .rst           (rst),
        .bus_disable   (bus_disable),
        .exec_internal (exec_internal),
        .narrow_bus    (narrow_bus),
        .own_state     (own_state),
        .port_mask     (port_mask)
    );

    genvar p;
    generate
        for (p = 0; p < W; p++) begin : g_pin
            assign pad_out[p] = port_mask[p] ? lat_q[p]  : bus_strobe[p];
            assign pad_oe[p]  = port_mask[p] ? !dir_q[p] : 1'b1;
        end
    endgenerate

endmodule

// File: rtl/busmux_gpio_port_chk.sv
module busmux_gpio_port_chk
    import gpio_mux_pkg::*;
#(
    parameter int W          = 5,
    parameter int NARROW_PIN = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_disable,
    input logic              exec_internal,
    input logic              narrow_bus,
    input logic [W-1:0]      bus_strobe,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic [W-1:0]      reg_wdata,
    input logic [W-1:0]      reg_rdata,
    input logic [W-1:0]      pad_in,
    input logic [W-1:0]      pad_out,
    input logic [W-1:0]      pad_oe,
    input logic [W-1:0]      lat_q,
    input logic [W-1:0]      dir_q,
    input own_e              own_state
);

    logic [1:0]   run_cnt;
    logic         past_ok;
    logic [W-1:0] narrow_bit;

    always_ff @(posedge clk) begin
        if (rst)               run_cnt <= '0;
        else if (run_cnt != 2) run_cnt <= run_cnt + 2'd1;
    end
    assign past_ok    = (run_cnt != 0);
    assign narrow_bit = W'(1) << NARROW_PIN;

    assert_reset_defaults_R1: assert property (@(posedge clk)
        $past(rst) |-> (dir_q == '1 && lat_q == '0 && own_state == OWN_BUS));

    assert_latch_write_R2: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(reg_we && reg_addr == ADDR_LAT)) |-> lat_q == $past(reg_wdata));

    assert_port_write_R3: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(reg_we && reg_addr == ADDR_PORT)) |-> lat_q == $past(reg_wdata));

    assert_port_data_R4: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(bus_disable && exec_internal)) |-> ((pad_out ^ lat_q) & pad_oe) == '0);

    assert_dir_drive_R5: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(bus_disable && exec_internal)) |-> pad_oe == ~dir_q);

    assert_sync_lag_R6: assert property (@(posedge clk) disable iff (rst)
        (run_cnt == 2 && reg_addr == ADDR_PORT) |-> reg_rdata == $past(pad_in, 2));

    assert_port_owner_R7: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(bus_disable && exec_internal)) |-> own_state == OWN_PORT);

    assert_narrow_pin_R8: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(!exec_internal && narrow_bus)) |->
            (((pad_out ^ bus_strobe) & ~narrow_bit) == '0 &&
             (pad_oe | narrow_bit) == '1 &&
             pad_oe[NARROW_PIN] == !dir_q[NARROW_PIN]));

    assert_bus_owner_R9: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(!(bus_disable && exec_internal) && !(!exec_internal && narrow_bus)))
            |-> (pad_oe == '1 && pad_out == bus_strobe));

    assert_rsvd_write_R11: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(reg_we && reg_addr == ADDR_RSVD)) |-> ($stable(lat_q) && $stable(dir_q)));

    assert_rsvd_read_R11: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_RSVD) |-> reg_rdata == '0);

endmodule

bind busmux_gpio_port busmux_gpio_port_chk #(.W(W), .NARROW_PIN(NARROW_PIN)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_disable   (bus_disable),
    .exec_internal (exec_internal),
    .narrow_bus    (narrow_bus),
    .bus_strobe    (bus_strobe),
    .reg_we        (reg_we),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .pad_in        (pad_in),
    .pad_out       (pad_out),
    .pad_oe        (pad_oe),
    .lat_q         (lat_q),
    .dir_q         (dir_q),
    .own_state     (own_state)
);

// File: tb/busmux_gpio_port_tb.sv
module busmux_gpio_port_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_disable = 1'b0;
    logic       exec_internal = 1'b0;
    logic       narrow_bus = 1'b0;
    logic [4:0] bus_strobe = 5'h00;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [4:0] reg_wdata = 5'h00;
    logic [4:0] reg_rdata;
    logic [4:0] pad_in = 5'h00;
    logic [4:0] pad_out;
    logic [4:0] pad_oe;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    busmux_gpio_port u_dut (
        .clk           (clk),
        .rst           (rst),
        .bus_disable   (bus_disable),
        .exec_internal (exec_internal),
        .narrow_bus    (narrow_bus),
        .bus_strobe    (bus_strobe),
        .reg_we        (reg_we),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .pad_in        (pad_in),
        .pad_out       (pad_out),
        .pad_oe        (pad_oe)
    );

    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [4:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [4:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic set_mode(input logic dis, input logic inte, input logic nar);
        bus_disable = dis; exec_internal = inte; narrow_bus = nar;
        step();
    endtask

    task automatic t_reset();
        logic [4:0] v;
        bus_strobe = 5'h16;
        rd(2'd2, v); chk("R1 dir reset", v, 5'h1F);
        rd(2'd1, v); chk("R1 latch reset", v, 5'h00);
        chk("R1 oe reset", pad_oe, 5'h1F);
        chk("R1 out reset", pad_out, 5'h16);
    endtask

    task automatic t_latch();
        logic [4:0] v;
        wr(2'd1, 5'h19); rd(2'd1, v); chk("R2 latch write", v, 5'h19);
        wr(2'd0, 5'h06); rd(2'd1, v); chk("R3 port write to latch", v, 5'h06);
    endtask

    task automatic t_port_mode();
        logic [4:0] v;
        wr(2'd1, 5'h1A);
        wr(2'd2, 5'h04);
        rd(2'd2, v); chk("R5 dir readback", v, 5'h04);
        bus_disable = 1'b1; exec_internal = 1'b1; narrow_bus = 1'b0;
        #1;
        chk("R7 still bus before edge", pad_oe, 5'h1F);
        step();
        chk("R4 oe for dir 04", pad_oe, 5'b11011);
        chk("R4 out on driven pins", pad_out & pad_oe, 5'h1A & 5'b11011);
        wr(2'd2, 5'h1F);
        chk("R5 all inputs", pad_oe, 5'h00);
        wr(2'd2, 5'h04);
    endtask

    task automatic t_modes();
        bus_strobe = 5'h0D;
        set_mode(1'b0, 1'b1, 1'b0);
        chk("R9 internal bus enabled oe", pad_oe, 5'h1F);
        chk("R9 internal bus enabled out", pad_out, 5'h0D);
        set_mode(1'b1, 1'b1, 1'b1);
        chk("R7 port mode narrow ignored", pad_oe, 5'b11011);
        set_mode(1'b0, 1'b0, 1'b1);
        chk("R8 narrow oe", pad_oe, 5'h1F);
        chk("R8 narrow out", pad_out, (5'h0D & 5'b10111) | (5'h1A & 5'b01000));
        wr(2'd2, 5'h08);
        chk("R8 narrow pin input", pad_oe, 5'b10111);
        chk("R8 narrow other strobes", pad_out & 5'b10111, 5'h0D & 5'b10111);
        bus_strobe = 5'h12;
        set_mode(1'b1, 1'b0, 1'b1);
        chk("R8 disable set external", pad_out & 5'b10111, 5'h12);
        set_mode(1'b1, 1'b0, 1'b0);
        chk("R9 external wide oe", pad_oe, 5'h1F);
        chk("R9 external wide out", pad_out, 5'h12);
        wr(2'd2, 5'h04);
    endtask

    task automatic t_sync();
        logic [4:0] v;
        pad_in = 5'h00; step(); step(); step();
        pad_in = 5'h15;
        rd(2'd0, v); chk("R6 before edge", v, 5'h00);
        step(); rd(2'd0, v); chk("R6 one clock lag", v, 5'h00);
        step(); rd(2'd0, v); chk("R6 after two clocks", v, 5'h15);
    endtask

    task automatic t_latch_vs_pin();
        logic [4:0] v;
        wr(2'd1, 5'h0A);
        pad_in = 5'h1F; step(); step();
        rd(2'd1, v); chk("R10 latch not pins", v, 5'h0A);
        rd(2'd0, v); chk("R10 port reads pins", v, 5'h1F);
    endtask

    task automatic t_reserved();
        logic [4:0] v;
        wr(2'd3, 5'h11);
        rd(2'd3, v); chk("R11 reserved reads zero", v, 5'h00);
        rd(2'd1, v); chk("R11 latch untouched", v, 5'h0A);
        rd(2'd2, v); chk("R11 dir untouched", v, 5'h04);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step();
        t_reset();
        t_latch();
        t_port_mode();
        t_modes();
        t_sync();
        t_latch_vs_pin();
        t_reserved();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule